// File: doc/BRIEF.md
# Activity-Monitor Virtual Offset Register Access Unit

This block sits in the system-register path of a processor core. It holds a small bank of 64-bit virtual offsets that are applied to activity-monitor event counters. For every register read or write that arrives, it decodes the instruction encoding fields. It then weighs the current privilege level together with the nested-virtualization and monitor-level control bits. From these it picks exactly one outcome for the access.

The possible outcomes are:

- the access is rejected as undefined;
- it traps to the hypervisor level;
- it traps to the monitor level;
- it is redirected to a memory slot whose address the block computes;
- it is served directly from the register bank.

Permission checking is combinational and settles in the cycle the access is presented. A direct write lands in the bank at the next rising clock edge. The rule for which indices are implemented, the memory base address, the syndrome class and the presence of the monitor level are all parameters.

Top module: `voff_access_unit`

## Requirements
- R1: While `acc_valid` is high, `outcome` has exactly one bit set, with bit 0 = direct, bit 1 = memory redirect, bit 2 = trap to level 2, bit 3 = trap to level 3, bit 4 = undefined. While `acc_valid` is low, `outcome` is zero.
- R2: An access whose encoding is not op0=3, op1=4, CRn=13 and CRm[3:1]=0b100 is undefined.
- R3: The slot index is {CRm[0], op2}. An index of 4 or more, or an index other than 0, 2 or 3, is undefined at every privilege level, including level 3.
- R4: An access from privilege level 0 is undefined.
- R5: At level 1 with control bits [2] and [0] both set, the access is a memory redirect to address 0xA00 + 8 × index.
- R6: At level 1 with control bit [0] set and bit [2] clear, the access traps to level 2, and `trap_class` is 0x18.
- R7: At level 1 with control bit [0] clear, the access is undefined.
- R8: At level 2 with the undefined-priority mode on, the access is undefined if the monitor-trap bit is set or the offset-enable bit is clear.
- R9: At level 2, with R8 not applying and offset-enable clear, the access is undefined if the debug-undefined condition holds. Otherwise it traps to level 3 with `trap_class` 0x18.
- R10: At level 2, with offset-enable set and the monitor-trap bit set, the access is undefined if the debug-undefined condition holds. Otherwise it traps to level 3 with `trap_class` 0x18.
- R11: At level 2 with none of R8 to R10 applying, and at level 3 always, the access goes directly to the bank.
- R12: Reads and writes follow the same permission rules. A direct write replaces all 64 bits, and the new value is visible to reads from the next cycle. A direct read returns all 64 bits. Any other outcome leaves the bank unchanged and reads as zero.
- R13: Reset clears every implemented slot to zero.
- R14: When built without the monitor level, a level-2 access to an implemented slot goes directly to the bank, whatever the monitor-level control bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| enc_op0 | input | 2 | Encoding field op0 |
| enc_op1 | input | 3 | Encoding field op1 |
| enc_crn | input | 4 | Encoding field CRn |
| enc_crm | input | 4 | Encoding field CRm |
| enc_op2 | input | 3 | Encoding field op2 |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| nv_ctl | input | 3 | Nested-virtualization control bits |
| mon_undef_prio | input | 1 | Undefined-priority mode is on |
| mon_undef_cond | input | 1 | Debug-undefined condition holds |
| mon_trap | input | 1 | Monitor-level trap bit for activity monitors |
| mon_offs_en | input | 1 | Monitor-level enable for virtual offsets |
| wr_data | input | 64 | Data for a write |
| outcome | output | 5 | One-hot access outcome |
| trap_class | output | 6 | Syndrome class when trapping, else 0 |
| mem_addr | output | 12 | Redirect address when redirecting, else 0 |
| rd_data | output | 64 | Data for a direct read, else 0 |

## Verification
The bench builds two copies of the block.

The first copy uses the default parameters: the monitor level is present and slots 0, 2 and 3 are implemented. This copy reaches the full level-2 priority chain and both trap targets. It also reaches the redirect addresses for the highest implemented slot, and the gaps at slot 1 and above slot 3.

The second copy is built with the monitor level absent. It shares the same inputs, so the same level-2 stimulus shows the chain collapsing to a direct access.

// File: rtl/voff_pkg.sv
package voff_pkg;

   typedef enum logic [1:0] {
      LVL_APP  = 2'd0,
      LVL_KERN = 2'd1,
      LVL_HYP  = 2'd2,
      LVL_MON  = 2'd3
   } priv_e;

   localparam int OC_W      = 5;
   localparam int OC_DIRECT = 0;
   localparam int OC_MEM    = 1;
   localparam int OC_TRAP2  = 2;
   localparam int OC_TRAP3  = 3;
   localparam int OC_UNDEF  = 4;

   typedef logic [OC_W-1:0] oc_t;

   typedef struct packed {
      logic undef_prio;
      logic undef_cond;
      logic trap_bit;
      logic offs_en;
   } mon_ctl_t;

   function automatic oc_t oc_bit(input int pos);
      oc_t v;
      v = '0;
      v[pos] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/voff_decode.sv
module voff_decode
   import voff_pkg::*;
#(
   parameter int IDX_W      = 4,
   parameter int SLOT_LIMIT = 4,
   parameter logic [(1<<IDX_W)-1:0] IMPL_MASK = 16'h000D
) (
   input  logic [1:0]       op0,
   input  logic [2:0]       op1,
   input  logic [3:0]       crn,
   input  logic [3:0]       crm,
   input  logic [2:0]       op2,
   output logic             grp_hit,
   output logic [IDX_W-1:0] idx,
   output logic             slot_ok
);

   localparam int SLOTS = 1 << IDX_W;

   logic [SLOTS-1:0] usable;

   // A slot is usable only below the limit and when its mask bit is set.
   for (genvar s = 0; s < SLOTS; s++) begin : g_usable
      if (s < SLOT_LIMIT) begin : g_in
         assign usable[s] = IMPL_MASK[s];
      end else begin : g_out
         assign usable[s] = 1'b0;
      end
   end

   always_comb begin
      grp_hit = (op0 == 2'b11) && (op1 == 3'b100) &&
                (crn == 4'b1101) && (crm[3:1] == 3'b100);
      idx     = IDX_W'({crm[0], op2});
      slot_ok = grp_hit && usable[idx];
   end

endmodule

// File: rtl/voff_perm.sv
module voff_perm
   import voff_pkg::*;
#(
   parameter bit HAS_MON = 1'b1
) (
   input  logic     slot_ok,
   input  priv_e    priv,
   input  logic [2:0] nv,
   input  mon_ctl_t mon,
   output oc_t      oc
);

   oc_t hyp_oc;
   oc_t kern_oc;

   // Level 1: redirect, trap to level 2, or undefined.
   always_comb begin
      if (nv[2] && nv[0])
         kern_oc = oc_bit(OC_MEM);
      else if (nv[0])
         kern_oc = oc_bit(OC_TRAP2);
      else
         kern_oc = oc_bit(OC_UNDEF);
   end

   // Level 2: strict priority chain when the monitor level exists.
   if (HAS_MON) begin : g_mon
      always_comb begin
         if (mon.undef_prio && mon.trap_bit)
            hyp_oc = oc_bit(OC_UNDEF);
         else if (mon.undef_prio && !mon.offs_en)
            hyp_oc = oc_bit(OC_UNDEF);
         else if (!mon.offs_en)
            hyp_oc = mon.undef_cond ? oc_bit(OC_UNDEF) : oc_bit(OC_TRAP3);
         else if (mon.trap_bit)
            hyp_oc = mon.undef_cond ? oc_bit(OC_UNDEF) : oc_bit(OC_TRAP3);
         else
            hyp_oc = oc_bit(OC_DIRECT);
      end
   end else begin : g_nomon
      always_comb hyp_oc = oc_bit(OC_DIRECT);
   end

   always_comb begin
      if (!slot_ok) begin
         oc = oc_bit(OC_UNDEF);
      end else begin
         unique case (priv)
            LVL_APP:  oc = oc_bit(OC_UNDEF);
            LVL_KERN: oc = kern_oc;
            LVL_HYP:  oc = hyp_oc;
            LVL_MON:  oc = oc_bit(OC_DIRECT);
            default:  oc = oc_bit(OC_UNDEF);
         endcase
      end
   end

endmodule

// File: rtl/voff_bank.sv
module voff_bank #(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 4,
   parameter logic [(1<<IDX_W)-1:0] IMPL_MASK = 16'h000D
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               idx,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [DATA_W-1:0]              rd_data,
   output logic [(1<<IDX_W)*DATA_W-1:0]   bank_flat
);

   localparam int SLOTS = 1 << IDX_W;

   logic [DATA_W-1:0] slot_q [SLOTS];

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (IMPL_MASK[s]) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[s] <= '0;
            else if (wr_en && (idx == IDX_W'(s)))
               slot_q[s] <= wr_data;
         end
      end else begin : g_tie
         assign slot_q[s] = '0;
      end
      assign bank_flat[s*DATA_W +: DATA_W] = slot_q[s];
   end

   assign rd_data = slot_q[idx];

endmodule

// File: rtl/voff_access_unit.sv
module voff_access_unit
   import voff_pkg::*;
#(
   parameter int DATA_W     = 64,
   parameter int IDX_W      = 4,
   parameter int SLOT_LIMIT = 4,
   parameter logic [(1<<IDX_W)-1:0] IMPL_MASK = 16'h000D,
   parameter int ADDR_W     = 12,
   parameter logic [11:0] MEM_BASE = 12'hA00,
   parameter int SLOT_BYTES = 8,
   parameter logic [5:0] SYND_CLASS = 6'h18,
   parameter bit HAS_MON    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [1:0]        enc_op0,
   input  logic [2:0]        enc_op1,
   input  logic [3:0]        enc_crn,
   input  logic [3:0]        enc_crm,
   input  logic [2:0]        enc_op2,
   input  logic [1:0]        priv_lvl,
   input  logic [2:0]        nv_ctl,
   input  logic              mon_undef_prio,
   input  logic              mon_undef_cond,
   input  logic              mon_trap,
   input  logic              mon_offs_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [OC_W-1:0]   outcome,
   output logic [5:0]        trap_class,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int SLOTS = 1 << IDX_W;

   // Elaboration-time parameter checks.
   if (IDX_W != 4) begin : g_bad_idx
      $error("voff_access_unit: index is CRm[0] with op2, IDX_W must be 4");
   end
   if (SLOT_LIMIT < 1 || SLOT_LIMIT > SLOTS) begin : g_bad_lim
      $error("voff_access_unit: SLOT_LIMIT out of range");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("voff_access_unit: DATA_W must be positive");
   end
   if (ADDR_W < 12) begin : g_bad_aw
      $error("voff_access_unit: ADDR_W too small for MEM_BASE");
   end
   if ((SLOT_BYTES & (SLOT_BYTES - 1)) != 0) begin : g_bad_sb
      $error("voff_access_unit: SLOT_BYTES must be a power of two");
   end

   logic             grp_hit;
   logic [IDX_W-1:0] idx;
   logic             slot_ok;
   oc_t              perm_oc;
   mon_ctl_t         mon;
   logic             wr_en;
   logic [DATA_W-1:0] bank_rd;
   logic [SLOTS*DATA_W-1:0] bank_flat;

   assign mon = '{undef_prio: mon_undef_prio, undef_cond: mon_undef_cond,
                  trap_bit: mon_trap, offs_en: mon_offs_en};

   voff_decode #(
      .IDX_W(IDX_W), .SLOT_LIMIT(SLOT_LIMIT), .IMPL_MASK(IMPL_MASK)
   ) u_decode (
      .op0(enc_op0), .op1(enc_op1), .crn(enc_crn), .crm(enc_crm), .op2(enc_op2),
      .grp_hit(grp_hit), .idx(idx), .slot_ok(slot_ok)
   );

   voff_perm #(.HAS_MON(HAS_MON)) u_perm (
      .slot_ok(slot_ok), .priv(priv_e'(priv_lvl)), .nv(nv_ctl), .mon(mon),
      .oc(perm_oc)
   );

   voff_bank #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .IMPL_MASK(IMPL_MASK)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wr_data(wr_data),
      .rd_data(bank_rd), .bank_flat(bank_flat)
   );

   always_comb begin
      outcome    = acc_valid ? perm_oc : '0;
      wr_en      = acc_valid && acc_write && perm_oc[OC_DIRECT];
      rd_data    = (acc_valid && !acc_write && perm_oc[OC_DIRECT]) ? bank_rd : '0;
      trap_class = (outcome[OC_TRAP2] || outcome[OC_TRAP3]) ? SYND_CLASS : 6'd0;
      mem_addr   = outcome[OC_MEM]
                   ? ADDR_W'(MEM_BASE) + ADDR_W'(idx) * ADDR_W'(SLOT_BYTES)
                   : '0;
   end

endmodule

// File: rtl/voff_access_chk.sv
module voff_access_chk
   import voff_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int IDX_W   = 4,
   parameter int ADDR_W  = 12,
   parameter logic [(1<<IDX_W)-1:0] IMPL_MASK = 16'h000D,
   parameter logic [11:0] MEM_BASE = 12'hA00,
   parameter logic [5:0] SYND_CLASS = 6'h18
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          acc_valid,
   input logic                          acc_write,
   input logic [3:0]                    enc_crm,
   input logic [2:0]                    enc_op2,
   input logic [1:0]                    priv_lvl,
   input logic [OC_W-1:0]               outcome,
   input logic [5:0]                    trap_class,
   input logic [ADDR_W-1:0]             mem_addr,
   input logic [(1<<IDX_W)*DATA_W-1:0]  bank_flat
);

   logic [3:0] chk_idx;
   assign chk_idx = {enc_crm[0], enc_op2};

   // R1: one outcome per access, none when idle
   a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> $countones(outcome) == 1);
   a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> outcome == '0);

   // R3: slots outside the implemented set are undefined
   a_r3_gap_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && (chk_idx >= 4 || chk_idx == 1)) |-> outcome[OC_UNDEF]);

   // R4: level 0 never gets through
   a_r4_app_undef: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && priv_lvl == 2'd0) |-> outcome[OC_UNDEF]);

   // R5: redirect address is aligned and at or above the base
   a_r5_redirect_addr: assert property (@(posedge clk) disable iff (!rst_n)
      outcome[OC_MEM] |-> (mem_addr[2:0] == 3'b000 &&
                           mem_addr >= ADDR_W'(MEM_BASE) && priv_lvl == 2'd1));

   // R6: a trap carries the syndrome class
   a_r6_trap_class: assert property (@(posedge clk) disable iff (!rst_n)
      (outcome[OC_TRAP2] || outcome[OC_TRAP3]) |-> trap_class == SYND_CLASS);

   // R12: the bank moves only after a direct write
   a_r12_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write && outcome[OC_DIRECT]) |=> $stable(bank_flat));

   // R13: reset leaves the bank clear
   a_r13_reset_clear: assert property (@(posedge clk)
      !rst_n |=> bank_flat == '0);

endmodule

bind voff_access_unit voff_access_chk #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK),
   .MEM_BASE(MEM_BASE), .SYND_CLASS(SYND_CLASS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
   .enc_crm(enc_crm), .enc_op2(enc_op2), .priv_lvl(priv_lvl),
   .outcome(outcome), .trap_class(trap_class), .mem_addr(mem_addr),
   .bank_flat(bank_flat)
);

// File: tb/test_voff_access_unit.sv
`timescale 1ns/1ps
module test_voff_access_unit;

   localparam logic [4:0] O_DIR = 5'b00001;
   localparam logic [4:0] O_MEM = 5'b00010;
   localparam logic [4:0] O_T2  = 5'b00100;
   localparam logic [4:0] O_T3  = 5'b01000;
   localparam logic [4:0] O_UND = 5'b10000;

   // {lvl[2], nv[3], prio, cond, trap, offs_en, idx[4], expected outcome[5]}
   localparam int NV = 20;
   localparam logic [17:0] VEC [NV] = '{
      {2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0,  O_UND}, // R4
      {2'd1, 3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0,  O_MEM}, // R5
      {2'd1, 3'b111, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3,  O_MEM}, // R5
      {2'd1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2,  O_T2},  // R6
      {2'd1, 3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2,  O_T2},  // R6
      {2'd1, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0,  O_UND}, // R7
      {2'd1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3,  O_UND}, // R7
      {2'd2, 3'b000, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0,  O_UND}, // R8
      {2'd2, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2,  O_UND}, // R8
      {2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2,  O_T3},  // R9
      {2'd2, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3,  O_UND}, // R9
      {2'd2, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0,  O_T3},  // R10
      {2'd2, 3'b000, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0,  O_UND}, // R10
      {2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3,  O_DIR}, // R11
      {2'd2, 3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  O_DIR}, // R11
      {2'd3, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2,  O_DIR}, // R11
      {2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1,  O_UND}, // R3
      {2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4,  O_UND}, // R3
      {2'd1, 3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1,  O_UND}, // R3
      {2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd15, O_UND}  // R3
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [1:0]  enc_op0 = 2'b11;
   logic [2:0]  enc_op1 = 3'b100;
   logic [3:0]  enc_crn = 4'b1101;
   logic [3:0]  enc_crm = 4'b1000;
   logic [2:0]  enc_op2 = 3'b000;
   logic [1:0]  priv_lvl = 2'd0;
   logic [2:0]  nv_ctl = 3'b000;
   logic        mon_undef_prio = 1'b0;
   logic        mon_undef_cond = 1'b0;
   logic        mon_trap = 1'b0;
   logic        mon_offs_en = 1'b1;
   logic [63:0] wr_data = '0;
   logic [4:0]  outcome, outcome_n;
   logic [5:0]  trap_class, trap_class_n;
   logic [11:0] mem_addr, mem_addr_n;
   logic [63:0] rd_data, rd_data_n;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   voff_access_unit i_voff_access_unit (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn),
      .enc_crm(enc_crm), .enc_op2(enc_op2), .priv_lvl(priv_lvl),
      .nv_ctl(nv_ctl), .mon_undef_prio(mon_undef_prio),
      .mon_undef_cond(mon_undef_cond), .mon_trap(mon_trap),
      .mon_offs_en(mon_offs_en), .wr_data(wr_data), .outcome(outcome),
      .trap_class(trap_class), .mem_addr(mem_addr), .rd_data(rd_data)
   );

   voff_access_unit #(.HAS_MON(1'b0)) i_voff_access_unit_nomon (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .enc_op0(enc_op0), .enc_op1(enc_op1), .enc_crn(enc_crn),
      .enc_crm(enc_crm), .enc_op2(enc_op2), .priv_lvl(priv_lvl),
      .nv_ctl(nv_ctl), .mon_undef_prio(mon_undef_prio),
      .mon_undef_cond(mon_undef_cond), .mon_trap(mon_trap),
      .mon_offs_en(mon_offs_en), .wr_data(wr_data), .outcome(outcome_n),
      .trap_class(trap_class_n), .mem_addr(mem_addr_n), .rd_data(rd_data_n)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one access at the falling edge; outputs settle 1 ns later.
   task automatic drive(input logic [1:0] lvl, input logic [2:0] nv,
                        input logic prio, input logic cond, input logic trp,
                        input logic en, input logic [3:0] idx,
                        input logic wr, input logic [63:0] data);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; wr_data = data;
      enc_op0 = 2'b11; enc_op1 = 3'b100; enc_crn = 4'b1101;
      enc_crm = {3'b100, idx[3]}; enc_op2 = idx[2:0];
      priv_lvl = lvl; nv_ctl = nv; mon_undef_prio = prio;
      mon_undef_cond = cond; mon_trap = trp; mon_offs_en = en;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
      #1;
   endtask

   initial begin
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      check("R1 idle outcome", 64'(outcome), 64'd0);

      // Table walk, read accesses.
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][17:16], VEC[i][15:13], VEC[i][12], VEC[i][11],
               VEC[i][10], VEC[i][9], VEC[i][8:5], 1'b0, '0);
         check($sformatf("R1-table row %0d outcome", i), 64'(outcome), 64'(VEC[i][4:0]));
         if (VEC[i][4:0] == O_MEM)
            check("R5 redirect address", 64'(mem_addr),
                  64'(12'hA00 + 12'(VEC[i][8:5]) * 12'd8));
         if (VEC[i][4:0] == O_T2 || VEC[i][4:0] == O_T3)
            check("R6 trap class", 64'(trap_class), 64'h18);
      end

      // R13: slots read zero after reset.
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, '0);
      check("R13 slot0 reset", rd_data, 64'd0);
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0, '0);
      check("R13 slot3 reset", rd_data, 64'd0);

      // R12: full 64-bit write and read-back.
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 64'hDEAD_BEEF_0123_4567);
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0, '0);
      check("R12 slot2 readback", rd_data, 64'hDEAD_BEEF_0123_4567);
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, '0);
      check("R12 slot0 untouched", rd_data, 64'd0);

      // R11: direct write from level 2.
      drive(2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b1, 64'hFFFF_0000_FFFF_0001);
      drive(2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0, '0);
      check("R11 level2 direct read", rd_data, 64'hFFFF_0000_FFFF_0001);

      // R12: redirected write leaves the bank alone.
      drive(2'd1, 3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b1, 64'h1111_2222_3333_4444);
      check("R5 write redirect address", 64'(mem_addr), 64'hA18);
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0, '0);
      check("R12 redirect no write", rd_data, 64'hFFFF_0000_FFFF_0001);

      // R9: trapped write leaves the bank alone.
      drive(2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 64'h5555_5555_5555_5555);
      check("R9 write traps", 64'(outcome), 64'(O_T3));
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, '0);
      check("R9 trapped write ignored", rd_data, 64'd0);

      // R3: write to a gap slot is undefined and changes nothing.
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b1, 64'h7777_7777_7777_7777);
      check("R3 gap write outcome", 64'(outcome), 64'(O_UND));
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, '0);
      check("R3 gap read data", rd_data, 64'd0);
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0, '0);
      check("R3 slot2 unchanged", rd_data, 64'hDEAD_BEEF_0123_4567);

      // R2: wrong encoding field.
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0, '0);
      enc_op1 = 3'b011;
      #1;
      check("R2 wrong op1", 64'(outcome), 64'(O_UND));
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0, '0);
      enc_crn = 4'b1100;
      #1;
      check("R2 wrong crn", 64'(outcome), 64'(O_UND));

      // R14: without the monitor level, level 2 goes direct.
      drive(2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2, 1'b0, '0);
      check("R14 offs_en clear", 64'(outcome_n), 64'(O_DIR));
      drive(2'd2, 3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 4'd0, 1'b0, '0);
      check("R14 all monitor bits", 64'(outcome_n), 64'(O_DIR));
      drive(2'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0, '0);
      check("R14 gap still undefined", 64'(outcome_n), 64'(O_UND));

      // R1: idle again.
      idle();
      check("R1 idle after traffic", 64'(outcome), 64'd0);

      // R13: reset mid-run clears written slots.
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b0, '0);
      check("R13 slot2 after reset", rd_data, 64'd0);
      drive(2'd3, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0, '0);
      check("R13 slot3 after reset", rd_data, 64'd0);
      idle();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule